// File: doc/BRIEF.md
# Queued Load/Store Unit

This unit executes memory micro-ops for an out-of-order core. Each op arrives with a base register value, a 12-bit immediate offset, store data, an access size, a signedness bit, a load/store opcode, a destination register and a reorder-buffer tag. The unit adds the sign-extended offset to the base and checks that the address is aligned to the access size. An aligned op is placed in a small FIFO. A misaligned op never enters the FIFO. It is reported back at once with an exception flag and a cause code.

Only the op at the head of the FIFO may present a request to the data cache, over a valid/ready channel. A store is finished when its request is accepted. A load waits for its response on a second valid/ready channel, and only one load can be waiting at a time. The response word is trimmed to the access size and then sign- or zero-extended. Every finished op produces a one-cycle completion pulse carrying its reorder-buffer tag. A completed load also carries its destination register and its data. A stall input freezes all three handshakes.

Top module: `lsq_unit`

## Requirements
- R1: The request address is the base value plus the 12-bit offset sign-extended to 64 bits.
- R2: Requests leave in the order their ops were accepted. Each request presents the op's opcode (1 = store, 0 = load), its size code (00 byte, 01 half, 10 word, 11 double) and its store data, and it is presented only while the FIFO is not empty.
- R3: `in_ready` is low while the FIFO holds DEPTH ops (default 4). The FIFO never overflows.
- R4: A store completes one cycle after its request handshake. The pulse carries the store's tag, with `ld_valid` and `exc_valid` low.
- R5: After a load request is accepted, no further request is presented until that load's response has been taken. The load completes one cycle after the response handshake, with `ld_valid` high, its destination register and its tag.
- R6: Load data takes the low 1, 2, 4 or 8 bytes of the response word, according to the size code. The signedness bit decides the extension: 1 means zero-extend, 0 means sign-extend.
- R7: An op is misaligned when address bit 0 is set for a half, bits 1:0 are nonzero for a word, or bits 2:0 are nonzero for a double. Such an op sends no request and completes one cycle after it is accepted, with `exc_valid` high and cause 4 for a load or 6 for a store.
- R8: While `stall` is high, `in_ready`, `req_valid` and `resp_ready` are all low.
- R9: In a cycle where a misaligned op is accepted, `req_valid` and `resp_ready` are held low. As a result, at most one completion is produced per cycle.
- R10: After reset, `in_ready` is high, and `req_valid`, `resp_ready` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes all handshakes |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op accepted when valid |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | Access size code |
| in_unsigned | input | 1 | 1 = zero-extend load |
| in_base | input | 64 | Base register value |
| in_imm | input | IMM_W | Signed address offset |
| in_wdata | input | 64 | Store data |
| in_rd | input | 5 | Destination register |
| in_rob | input | ROB_W | Reorder-buffer tag |
| req_valid | output | 1 | Cache request valid |
| req_is_store | output | 1 | Request opcode |
| req_size | output | 2 | Request size code |
| req_addr | output | 64 | Request address |
| req_wdata | output | 64 | Request store data |
| req_ready | input | 1 | Cache accepts request |
| resp_valid | input | 1 | Cache response valid |
| resp_data | input | 64 | Cache response word |
| resp_ready | output | 1 | Unit accepts response |
| done_valid | output | 1 | Completion pulse |
| done_rob | output | ROB_W | Tag of the completed op |
| ld_valid | output | 1 | Completion carries load data |
| ld_rd | output | 5 | Load destination register |
| ld_data | output | 64 | Extended load data |
| exc_valid | output | 1 | Completion is an exception |
| exc_cause | output | 5 | Exception cause code |

## Verification
The assertions assume a cache that never drives `resp_valid` unless a load is waiting, and that keeps a response valid until it is taken. The bench's cache model follows this rule: it raises a response only after it has seen a load request accepted, and holds it until `resp_ready`.

Operands are drawn at random but shaped so that the offsets are usually aligned to the chosen size. Misalignment is injected on purpose by setting offset bit 0 on a non-byte access. Phases with the request channel held off, and phases with heavy stalling, drive the FIFO to full and freeze it. One phase returns a fixed response pattern whose sign bits are set, so that both signed and unsigned extension are exercised for every size.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        SZ_B = 2'b00,
        SZ_H = 2'b01,
        SZ_W = 2'b10,
        SZ_D = 2'b11
    } acc_size_e;

    localparam logic [4:0] CAUSE_LD_ALIGN = 5'd4;
    localparam logic [4:0] CAUSE_ST_ALIGN = 5'd6;

    typedef struct packed {
        logic            is_store;
        acc_size_e       size;
        logic            unsigned_ld;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wdata;
        logic [4:0]      rd;
    } mem_op_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [2:0] lo);
        case (sz)
            SZ_B:    return 1'b0;
            SZ_H:    return lo[0];
            SZ_W:    return |lo[1:0];
            default: return |lo;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] extend_load(logic [XLEN-1:0] raw,
                                                    acc_size_e sz, logic uns);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_B: r = uns ? {{(XLEN-8){1'b0}}, raw[7:0]}
                          : {{(XLEN-8){raw[7]}}, raw[7:0]};
            SZ_H: r = uns ? {{(XLEN-16){1'b0}}, raw[15:0]}
                          : {{(XLEN-16){raw[15]}}, raw[15:0]};
            SZ_W: r = uns ? {{(XLEN-32){1'b0}}, raw[31:0]}
                          : {{(XLEN-32){raw[31]}}, raw[31:0]};
            default: r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsq_agu.sv
module lsq_agu
    import lsq_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  acc_size_e        size,
    output logic [XLEN-1:0]  addr,
    output logic             misaligned
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] offset;

    always_comb begin
        offset     = {{EXT_W{imm[IMM_W-1]}}, imm};
        addr       = base + offset;
        misaligned = is_misaligned(size, addr[2:0]);
    end
endmodule

// File: rtl/lsq_fifo.sv
module lsq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
    import lsq_pkg::*;
#(
    parameter int ROB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             hold,
    input  logic             head_valid,
    input  logic             head_is_store,
    input  acc_size_e        head_size,
    input  logic             head_uns,
    input  logic [4:0]       head_rd,
    input  logic [ROB_W-1:0] head_rob,
    input  logic             exc_fire,
    input  logic [ROB_W-1:0] exc_rob,
    input  logic [4:0]       exc_code,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             pop,
    input  logic             resp_valid,
    input  logic [XLEN-1:0]  resp_data,
    output logic             resp_ready,
    output logic             done_valid,
    output logic [ROB_W-1:0] done_rob,
    output logic             ld_valid,
    output logic [4:0]       ld_rd,
    output logic [XLEN-1:0]  ld_data,
    output logic             exc_valid,
    output logic [4:0]       exc_cause
);
    typedef struct packed {
        logic             busy;
        logic [ROB_W-1:0] rob;
        logic [4:0]       rd;
        acc_size_e        size;
        logic             uns;
    } wait_t;

    wait_t wt;
    logic  req_fire, st_fire, ld_issue, resp_fire;

    always_comb begin
        req_valid  = head_valid && !wt.busy && !stall && !hold;
        req_fire   = req_valid && req_ready;
        st_fire    = req_fire && head_is_store;
        ld_issue   = req_fire && !head_is_store;
        pop        = req_fire;
        resp_ready = wt.busy && !stall && !hold;
        resp_fire  = resp_ready && resp_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wt <= '0;
        end else if (ld_issue) begin
            wt <= '{busy: 1'b1, rob: head_rob, rd: head_rd,
                    size: head_size, uns: head_uns};
        end else if (resp_fire) begin
            wt.busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            done_rob   <= '0;
            ld_valid   <= 1'b0;
            ld_rd      <= '0;
            ld_data    <= '0;
            exc_valid  <= 1'b0;
            exc_cause  <= '0;
        end else begin
            done_valid <= exc_fire || st_fire || resp_fire;
            ld_valid   <= 1'b0;
            exc_valid  <= 1'b0;
            if (exc_fire) begin
                done_rob  <= exc_rob;
                exc_valid <= 1'b1;
                exc_cause <= exc_code;
            end else if (st_fire) begin
                done_rob <= head_rob;
            end else if (resp_fire) begin
                done_rob <= wt.rob;
                ld_valid <= 1'b1;
                ld_rd    <= wt.rd;
                ld_data  <= extend_load(resp_data, wt.size, wt.uns);
            end
        end
    end

    assert_one_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld_issue |=> !req_valid);
    assert_load_done_R5: assert property (@(posedge clk) disable iff (rst)
        resp_fire |=> done_valid && ld_valid && !exc_valid);
    assert_store_done_R4: assert property (@(posedge clk) disable iff (rst)
        st_fire |=> done_valid && !ld_valid && !exc_valid);
    assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_fire, st_fire, resp_fire}));
endmodule

// File: rtl/lsq_unit.sv
module lsq_unit
    import lsq_pkg::*;
#(
    parameter int ROB_W = 4,
    parameter int IMM_W = 12,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_is_store,
    input  logic [1:0]       in_size,
    input  logic             in_unsigned,
    input  logic [63:0]      in_base,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [63:0]      in_wdata,
    input  logic [4:0]       in_rd,
    input  logic [ROB_W-1:0] in_rob,
    output logic             req_valid,
    output logic             req_is_store,
    output logic [1:0]       req_size,
    output logic [63:0]      req_addr,
    output logic [63:0]      req_wdata,
    input  logic             req_ready,
    input  logic             resp_valid,
    input  logic [63:0]      resp_data,
    output logic             resp_ready,
    output logic             done_valid,
    output logic [ROB_W-1:0] done_rob,
    output logic             ld_valid,
    output logic [4:0]       ld_rd,
    output logic [63:0]      ld_data,
    output logic             exc_valid,
    output logic [4:0]       exc_cause
);
    localparam int OP_W = $bits(mem_op_t);
    localparam int QW   = OP_W + ROB_W;

    logic [XLEN-1:0]  eff_addr;
    logic             mis;
    logic             in_fire, exc_fire, push, pop, q_empty, q_full;
    mem_op_t          new_op, head_op;
    logic [ROB_W-1:0] head_rob;
    logic [QW-1:0]    q_din, q_dout;

    lsq_agu #(.IMM_W(IMM_W)) u_agu (
        .base       (in_base),
        .imm        (in_imm),
        .size       (acc_size_e'(in_size)),
        .addr       (eff_addr),
        .misaligned (mis)
    );

    always_comb begin
        in_ready = !q_full && !stall;
        in_fire  = in_valid && in_ready;
        exc_fire = in_fire && mis;
        push     = in_fire && !mis;
        new_op   = '{is_store: in_is_store, size: acc_size_e'(in_size),
                     unsigned_ld: in_unsigned, addr: eff_addr,
                     wdata: in_wdata, rd: in_rd};
        q_din    = {in_rob, new_op};
        head_op  = mem_op_t'(q_dout[OP_W-1:0]);
        head_rob = q_dout[QW-1:OP_W];
    end

    lsq_fifo #(.WIDTH(QW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (q_din),
        .pop   (pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    lsq_ctrl #(.ROB_W(ROB_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .stall         (stall),
        .hold          (exc_fire),
        .head_valid    (!q_empty),
        .head_is_store (head_op.is_store),
        .head_size     (head_op.size),
        .head_uns      (head_op.unsigned_ld),
        .head_rd       (head_op.rd),
        .head_rob      (head_rob),
        .exc_fire      (exc_fire),
        .exc_rob       (in_rob),
        .exc_code      (in_is_store ? CAUSE_ST_ALIGN : CAUSE_LD_ALIGN),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .pop           (pop),
        .resp_valid    (resp_valid),
        .resp_data     (resp_data),
        .resp_ready    (resp_ready),
        .done_valid    (done_valid),
        .done_rob      (done_rob),
        .ld_valid      (ld_valid),
        .ld_rd         (ld_rd),
        .ld_data       (ld_data),
        .exc_valid     (exc_valid),
        .exc_cause     (exc_cause)
    );

    assign req_is_store = head_op.is_store;
    assign req_size     = head_op.size;
    assign req_addr     = head_op.addr;
    assign req_wdata    = head_op.wdata;

    assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> !in_ready && !req_valid && !resp_ready);
    assert_exc_cause_R7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> done_valid && !ld_valid &&
                      (exc_cause == 5'd4 || exc_cause == 5'd6));
    assert_exc_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && mis) |-> !req_valid && !resp_ready);
endmodule

// File: tb/test_lsq_unit.sv
module test_lsq_unit;
    localparam int ROB_W = 4;
    localparam int IMM_W = 12;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 0, in_valid = 0, in_is_store = 0, in_unsigned = 0;
    logic [1:0] in_size = 0;
    logic [63:0] in_base = 0, in_wdata = 0, resp_data = 0;
    logic [IMM_W-1:0] in_imm = 0;
    logic [4:0] in_rd = 0;
    logic [ROB_W-1:0] in_rob = 0;
    logic req_ready = 0, resp_valid = 0;
    logic in_ready, req_valid, req_is_store, resp_ready, done_valid, ld_valid, exc_valid;
    logic [1:0] req_size;
    logic [63:0] req_addr, req_wdata, ld_data;
    logic [ROB_W-1:0] done_rob;
    logic [4:0] ld_rd, exc_cause;

    always #10 clk = ~clk;

    lsq_unit #(.ROB_W(ROB_W), .IMM_W(IMM_W), .DEPTH(DEPTH)) i_lsq_unit (
        .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_store(in_is_store), .in_size(in_size), .in_unsigned(in_unsigned),
        .in_base(in_base), .in_imm(in_imm), .in_wdata(in_wdata), .in_rd(in_rd),
        .in_rob(in_rob), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_ready(resp_ready), .done_valid(done_valid), .done_rob(done_rob),
        .ld_valid(ld_valid), .ld_rd(ld_rd), .ld_data(ld_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause));

    int vectors = 0, miscmp = 0;

    // knobs
    int in_pct = 50, rdy_pct = 60, stall_pct = 0, mis_pct = 10, st_pct = 50;
    bit fixed_resp = 0;

    // bench model
    logic        qs_st  [8];
    logic [1:0]  qs_sz  [8];
    logic        qs_un  [8];
    logic [63:0] qs_ad  [8];
    logic [63:0] qs_wd  [8];
    logic [4:0]  qs_rd  [8];
    logic [ROB_W-1:0] qs_rb [8];
    int qh = 0, qt = 0, qc = 0;
    bit m_wait = 0;
    int delay = 0;
    logic [ROB_W-1:0] w_rob;
    logic [4:0] w_rd;
    logic [1:0] w_sz;
    logic w_un;
    int exp_kind = 0;
    logic [ROB_W-1:0] e_rob;
    logic [4:0] e_cause, e_rd;
    logic [63:0] e_data;
    logic [ROB_W-1:0] tag = 0;

    task automatic chk(input string tag_s, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s actual=%h expected=%h", tag_s, what, act, exp);
        end
    endtask

    function automatic logic [63:0] b_addr(logic [63:0] b, logic [IMM_W-1:0] i);
        logic signed [63:0] s;
        s = 64'(signed'(i));
        return b + s;
    endfunction

    function automatic bit b_mis(logic [1:0] sz, logic [63:0] a);
        int n;
        n = 1 << sz;
        return (a % n) != 0;
    endfunction

    function automatic logic [63:0] b_ext(logic [63:0] raw, logic [1:0] sz, logic uns);
        int sh;
        logic signed [63:0] s;
        sh = 64 - 8 * (1 << sz);
        if (uns) return (raw << sh) >> sh;
        s = signed'(raw << sh);
        return s >>> sh;
    endfunction

    task automatic step();
        bit exp_in_ready, in_fire, mis, hold, exp_req_valid, exp_resp_ready, resp_fire;
        logic [63:0] a;
        @(negedge clk);
        // completion from events predicted one cycle earlier
        case (exp_kind)
            0: chk("R9", "no completion", done_valid, 0);
            1: begin // R7 misaligned completion
                chk("R7", "done_valid", done_valid, 1);
                chk("R7", "exc_valid", exc_valid, 1);
                chk("R7", "done_rob", done_rob, e_rob);
                chk("R7", "exc_cause", exc_cause, e_cause);
                chk("R7", "ld_valid", ld_valid, 0);
            end
            2: begin // R4 store completion
                chk("R4", "done_valid", done_valid, 1);
                chk("R4", "done_rob", done_rob, e_rob);
                chk("R4", "ld_valid", ld_valid, 0);
                chk("R4", "exc_valid", exc_valid, 0);
            end
            default: begin // R5 R6 load completion
                chk("R5", "done_valid", done_valid, 1);
                chk("R5", "ld_valid", ld_valid, 1);
                chk("R5", "done_rob", done_rob, e_rob);
                chk("R5", "ld_rd", ld_rd, e_rd);
                chk("R6", "ld_data", ld_data, e_data);
                chk("R5", "exc_valid", exc_valid, 0);
            end
        endcase
        exp_kind = 0;

        // drive
        stall = ($urandom % 100) < stall_pct;
        in_valid = ($urandom % 100) < in_pct;
        in_is_store = ($urandom % 100) < st_pct;
        in_size = 2'($urandom);
        in_unsigned = 1'($urandom);
        in_base = {$urandom, $urandom} & ~64'h7;
        in_imm = IMM_W'($urandom) & ~IMM_W'(7);
        in_imm = in_imm | (IMM_W'($urandom % 8) & ~IMM_W'((1 << in_size) - 1));
        if (in_size != 0 && ($urandom % 100) < mis_pct) in_imm = in_imm | IMM_W'(1);
        in_wdata = {$urandom, $urandom};
        in_rd = 5'($urandom);
        in_rob = tag;
        req_ready = ($urandom % 100) < rdy_pct;
        if (m_wait && delay > 0) delay--;
        resp_valid = m_wait && delay == 0;
        resp_data = fixed_resp ? 64'h8000_0000_8000_8080 : {$urandom, $urandom};
        #1;

        // predict
        exp_in_ready = !stall && qc < DEPTH;
        chk("R3 R8", "in_ready", in_ready, exp_in_ready);
        in_fire = in_valid && exp_in_ready;
        a = b_addr(in_base, in_imm);
        mis = b_mis(in_size, a);
        hold = in_fire && mis;
        exp_req_valid = qc > 0 && !m_wait && !stall && !hold;
        chk("R2 R5 R8 R9", "req_valid", req_valid, exp_req_valid);
        if (exp_req_valid && req_valid) begin
            chk("R1", "req_addr", req_addr, qs_ad[qh]);
            chk("R2", "req_is_store", req_is_store, qs_st[qh]);
            chk("R2", "req_size", req_size, qs_sz[qh]);
            if (qs_st[qh]) chk("R2", "req_wdata", req_wdata, qs_wd[qh]);
        end
        exp_resp_ready = m_wait && !stall && !hold;
        chk("R5 R8 R9", "resp_ready", resp_ready, exp_resp_ready);
        resp_fire = exp_resp_ready && resp_valid;

        if (hold) begin
            exp_kind = 1; e_rob = in_rob; e_cause = in_is_store ? 5'd6 : 5'd4;
        end else if (exp_req_valid && req_ready) begin
            if (qs_st[qh]) begin
                exp_kind = 2; e_rob = qs_rb[qh];
            end else begin
                m_wait = 1; w_rob = qs_rb[qh]; w_rd = qs_rd[qh];
                w_sz = qs_sz[qh]; w_un = qs_un[qh]; delay = 1 + $urandom % 3;
            end
            qh = (qh + 1) % 8; qc--;
        end else if (resp_fire) begin
            exp_kind = 3; e_rob = w_rob; e_rd = w_rd;
            e_data = b_ext(resp_data, w_sz, w_un); m_wait = 0;
        end
        if (in_fire) begin
            tag = tag + 1'b1;
            if (!mis) begin
                qs_st[qt] = in_is_store; qs_sz[qt] = in_size; qs_un[qt] = in_unsigned;
                qs_ad[qt] = a; qs_wd[qt] = in_wdata; qs_rd[qt] = in_rd;
                qs_rb[qt] = in_rob; qt = (qt + 1) % 8; qc++;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        miscmp++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R10 reset state
        chk("R10", "in_ready", in_ready, 1);
        chk("R10", "req_valid", req_valid, 0);
        chk("R10", "resp_ready", resp_ready, 0);
        chk("R10", "done_valid", done_valid, 0);

        // R3: fill the queue with the cache holding off
        in_pct = 100; rdy_pct = 0; mis_pct = 0; stall_pct = 0;
        repeat (10) step();
        rdy_pct = 100;
        repeat (20) step();

        // R7: misaligned-heavy traffic
        mis_pct = 60; in_pct = 70; rdy_pct = 70;
        repeat (300) step();

        // R6: loads with sign bits set in every lane
        fixed_resp = 1; st_pct = 0; mis_pct = 0;
        repeat (300) step();
        fixed_resp = 0; st_pct = 50;

        // R8: heavy stalling
        stall_pct = 40; mis_pct = 10;
        repeat (500) step();

        // mixed random traffic
        stall_pct = 10; in_pct = 50; rdy_pct = 60;
        repeat (3000) step();

        in_valid = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule